// File: doc/BRIEF.md
# Grouped Interrupt Request Hub with Vector Arbitration

This block gathers interrupt sources from two peripheral groups and presents a single prioritised request, with its vector number, to the processor. The port group has eight pins. Each pin has a flag bit and an enable bit, and all eight pins drive one shared request. The timer group has two requests. The first is a dedicated channel with its own request. The second is a shared request fed by five further sources: four compare channels and one overflow source. A global enable gates every request on its way to the processor.

The port group and the shared timer request each have a read-only code register. A read of that register returns the highest-priority pending source of the group and clears the flag of that one source. The dedicated timer channel needs no code register: its flag clears when the processor acknowledges its vector. Software reaches all registers over a simple single-cycle bus. The read data is combinational from the address, and the side effect of a read takes place at the clock edge while `bus_rd` is high.

Top module: `irq_vector_hub`

## Requirements
- R1: A port pin requests service only when its flag and its enable are both 1. The OR of the eight pin terms forms one port request, presented as vector 47.
- R2: Reading the port code register (offset 2) returns 2×(i+1) for the lowest-index pin i whose flag and enable are both 1. The read data is combinational in the same cycle.
- R3: A code read at offset 2 or offset 5 clears only the flag of the source it reported. Every other flag is left unchanged.
- R4: The dedicated timer channel (register offset 6: bit 0 is the flag, bit 1 is the enable) requests vector 53. Its flag clears at the clock edge where `irq_ack` is 1 while `irq_vec` is 53. An acknowledge of any other vector leaves the flag unchanged.
- R5: The five shared timer sources (flags at offset 3, enables at offset 4, code register at offset 5 using the same 2×(i+1) coding) form one request, presented as vector 52.
- R6: When several requests are active, `irq_vec` shows the highest vector number (53 over 52 over 47). When none is active, it shows 0.
- R7: When the global enable (offset 7, bit 0) is 0, `irq_req` is 0 and `irq_vec` is 0. All flags are kept.
- R8: When a hardware set event and a clear (code read or acknowledge) hit the same flag in one cycle, the flag ends up set.
- R9: A bus write to a flag register (offset 0, 3 or 6) loads the written value. Writing 1 raises a request on the next cycle. A hardware event in the same cycle still sets its bit.
- R10: Reading a code register while nothing in its group is pending returns 0 and changes no flag.
- R11: After reset, all flags, all enables and the global enable are 0, `irq_req` is 0 and `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; triggers read-to-clear at offsets 2 and 5 |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| port_evt | input | 8 | Per-pin flag set events |
| tmr_aux_evt | input | 5 | Set events for the shared timer sources |
| tmr_ded_evt | input | 1 | Set event for the dedicated timer channel |
| irq_ack | input | 1 | Processor acknowledge of the vector presented |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 6 | Vector number of the winning request, 0 when idle |

## Verification
Flags, enables and the global enable are registers. `irq_req` and `irq_vec` are combinational from them, so any write, event, code read or acknowledge shows up on `irq_vec` in the first cycle after the edge that captures it. Read data is due in the same cycle as the strobe, before the read's own clear takes effect. The bench drives inputs on the falling edge and samples read data and the vector one time unit later. It updates its reference state only at the rising edge, so each comparison is made against the state from before that edge. Directed cases cover the two-pin port read sequence, the set-versus-clear collision, acknowledge of the dedicated and the shared vectors, gating by the global enable, and idle code reads. Seeded random traffic covers everything else.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PFLAG = 3'd0,
    REG_PEN   = 3'd1,
    REG_PCODE = 3'd2,
    REG_AFLAG = 3'd3,
    REG_AEN   = 3'd4,
    REG_ACODE = 3'd5,
    REG_DCTL  = 3'd6,
    REG_GCTL  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      stage_q   <= 1'b0;
      rst_out_n <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_out_n <= stage_q;
    end
  end
endmodule

// File: rtl/irq_flag_group.sv
module irq_flag_group #(
  parameter int unsigned N      = 8,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      hw_set,
  input  logic              wr_flag,
  input  logic              wr_en,
  input  logic [N-1:0]      flag_wdata,
  input  logic [N-1:0]      en_wdata,
  input  logic              rd_clr,
  output logic [N-1:0]      flags,
  output logic [N-1:0]      enables,
  output logic [CODE_W-1:0] vec_code
);
  logic [N-1:0]      active;
  logic [N-1:0]      clr_mask;
  logic [N-1:0]      flag_d;
  logic [N-1:0]      en_d;
  logic [CODE_W-1:0] code_c;

  assign active = flags & enables;

  // lowest index wins: scan downwards so the last hit is the lowest
  always_comb begin
    code_c   = '0;
    clr_mask = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (active[i]) begin
        code_c   = CODE_W'(2 * (i + 1));
        clr_mask = N'(1) << i;
      end
    end
  end

  assign vec_code = code_c;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic nxt;
    always_comb begin
      nxt = flags[b];
      if (wr_flag) begin
        nxt = flag_wdata[b];
      end else if (rd_clr && clr_mask[b]) begin
        nxt = 1'b0;
      end
      if (hw_set[b]) begin
        nxt = 1'b1;
      end
    end
    assign flag_d[b] = nxt;
  end

  assign en_d = wr_en ? en_wdata : enables;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags   <= flag_d;
      enables <= en_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set))); // R8

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_flag && (hw_set == '0) && (vec_code != '0))
      |=> ($countones(flags) + 1 == $countones($past(flags)))); // R3

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_flag && (hw_set == '0) && (vec_code == '0))
      |=> (flags == $past(flags))); // R10
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter #(
  parameter int unsigned VEC_W   = 6,
  parameter int unsigned VEC_HI  = 53,
  parameter int unsigned VEC_MID = 52,
  parameter int unsigned VEC_LO  = 47
) (
  input  logic             gie,
  input  logic             req_hi,
  input  logic             req_mid,
  input  logic             req_lo,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  logic [2:0] gnt;

  always_comb begin
    gnt = 3'b000;
    if (gie) begin
      if (req_hi) begin
        gnt[2] = 1'b1;
      end else if (req_mid) begin
        gnt[1] = 1'b1;
      end else if (req_lo) begin
        gnt[0] = 1'b1;
      end
    end
  end

  always_comb begin
    irq_vec = '0;
    if (gnt[2]) begin
      irq_vec = VEC_W'(VEC_HI);
    end else if (gnt[1]) begin
      irq_vec = VEC_W'(VEC_MID);
    end else if (gnt[0]) begin
      irq_vec = VEC_W'(VEC_LO);
    end
  end

  assign irq_req = |gnt;

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(gnt)); // R6
  end
endmodule

// File: rtl/irq_vector_hub.sv
module irq_vector_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned AUX_W    = 5,
  parameter int unsigned VEC_DED  = 53,
  parameter int unsigned VEC_AUX  = 52,
  parameter int unsigned VEC_PORT = 47,
  localparam int unsigned VEC_MAX = (VEC_DED > VEC_AUX)
                                    ? ((VEC_DED > VEC_PORT) ? VEC_DED : VEC_PORT)
                                    : ((VEC_AUX > VEC_PORT) ? VEC_AUX : VEC_PORT),
  localparam int unsigned VEC_W   = $clog2(VEC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] port_evt,
  input  logic [AUX_W-1:0]  tmr_aux_evt,
  input  logic              tmr_ded_evt,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam logic [VEC_W-1:0] VEC_DED_C = VEC_W'(VEC_DED);

  logic              rst_sync_n;
  logic              gie_q;
  logic              gie_d;
  logic [PORT_W-1:0] p_flags;
  logic [PORT_W-1:0] p_en;
  logic [DATA_W-1:0] p_code;
  logic [AUX_W-1:0]  a_flags;
  logic [AUX_W-1:0]  a_en;
  logic [DATA_W-1:0] a_code;
  logic [0:0]        d_flag;
  logic [0:0]        d_en;
  logic [DATA_W-1:0] d_code;
  logic              sel_wr_pf;
  logic              sel_wr_pe;
  logic              sel_wr_af;
  logic              sel_wr_ae;
  logic              sel_wr_d;
  logic              sel_rd_p;
  logic              sel_rd_a;
  logic              ded_ack;

  irq_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  // register decode
  assign sel_wr_pf = bus_wr && (bus_addr == REG_PFLAG);
  assign sel_wr_pe = bus_wr && (bus_addr == REG_PEN);
  assign sel_wr_af = bus_wr && (bus_addr == REG_AFLAG);
  assign sel_wr_ae = bus_wr && (bus_addr == REG_AEN);
  assign sel_wr_d  = bus_wr && (bus_addr == REG_DCTL);
  assign sel_rd_p  = bus_rd && (bus_addr == REG_PCODE);
  assign sel_rd_a  = bus_rd && (bus_addr == REG_ACODE);
  assign ded_ack   = irq_ack && (irq_vec == VEC_DED_C);

  irq_flag_group #(.N(PORT_W), .CODE_W(DATA_W)) i_port_grp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hw_set     (port_evt),
    .wr_flag    (sel_wr_pf),
    .wr_en      (sel_wr_pe),
    .flag_wdata (bus_wdata[PORT_W-1:0]),
    .en_wdata   (bus_wdata[PORT_W-1:0]),
    .rd_clr     (sel_rd_p),
    .flags      (p_flags),
    .enables    (p_en),
    .vec_code   (p_code)
  );

  irq_flag_group #(.N(AUX_W), .CODE_W(DATA_W)) i_aux_grp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hw_set     (tmr_aux_evt),
    .wr_flag    (sel_wr_af),
    .wr_en      (sel_wr_ae),
    .flag_wdata (bus_wdata[AUX_W-1:0]),
    .en_wdata   (bus_wdata[AUX_W-1:0]),
    .rd_clr     (sel_rd_a),
    .flags      (a_flags),
    .enables    (a_en),
    .vec_code   (a_code)
  );

  // dedicated channel: one-source group, cleared by acknowledge
  irq_flag_group #(.N(1), .CODE_W(DATA_W)) i_ded_grp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hw_set     (tmr_ded_evt),
    .wr_flag    (sel_wr_d),
    .wr_en      (sel_wr_d),
    .flag_wdata (bus_wdata[0]),
    .en_wdata   (bus_wdata[1]),
    .rd_clr     (ded_ack),
    .flags      (d_flag),
    .enables    (d_en),
    .vec_code   (d_code)
  );

  // global enable
  always_comb begin
    gie_d = gie_q;
    if (bus_wr && (bus_addr == REG_GCTL)) begin
      gie_d = bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gie_q <= 1'b0;
    end else begin
      gie_q <= gie_d;
    end
  end

  irq_vec_arbiter #(
    .VEC_W   (VEC_W),
    .VEC_HI  (VEC_DED),
    .VEC_MID (VEC_AUX),
    .VEC_LO  (VEC_PORT)
  ) i_arb (
    .gie     (gie_q),
    .req_hi  (d_code != '0),
    .req_mid (a_code != '0),
    .req_lo  (p_code != '0),
    .irq_req (irq_req),
    .irq_vec (irq_vec)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_PFLAG: bus_rdata = DATA_W'(p_flags);
      REG_PEN:   bus_rdata = DATA_W'(p_en);
      REG_PCODE: bus_rdata = p_code;
      REG_AFLAG: bus_rdata = DATA_W'(a_flags);
      REG_AEN:   bus_rdata = DATA_W'(a_en);
      REG_ACODE: bus_rdata = a_code;
      REG_DCTL:  bus_rdata = DATA_W'({d_en, d_flag});
      REG_GCTL:  bus_rdata = DATA_W'(gie_q);
      default:   bus_rdata = '0;
    endcase
  end

  AST_DED_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ded_ack && !tmr_ded_evt && !sel_wr_d) |=> (d_flag == 1'b0)); // R4

  AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!gie_q) |-> (!irq_req && (irq_vec == '0))); // R7

  AST_PORT_REQ_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gie_q && ((p_flags & p_en) != '0)) |-> irq_req); // R1
endmodule

// File: tb/test_irq_vector_hub.sv
module test_irq_vector_hub;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic       bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] port_evt;
  logic [4:0] tmr_aux_evt;
  logic       tmr_ded_evt;
  logic       irq_ack;
  logic       irq_req;
  logic [5:0] irq_vec;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic done = 1'b0;

  // reference state
  logic [7:0] m_pf, m_pe;
  logic [4:0] m_af, m_ae;
  logic       m_df, m_de, m_gie;
  logic [7:0] last_rd;

  irq_vector_hub i_irq_vector_hub (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .port_evt    (port_evt),
    .tmr_aux_evt (tmr_aux_evt),
    .tmr_ded_evt (tmr_ded_evt),
    .irq_ack     (irq_ack),
    .irq_req     (irq_req),
    .irq_vec     (irq_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, 100000);
      report();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int code_of(input logic [7:0] act, input int n);
    int c = 0;
    for (int i = n - 1; i >= 0; i--) if (act[i]) c = 2 * (i + 1);
    return c;
  endfunction

  function automatic int exp_vec();
    if (!m_gie) return 0;
    if (m_df && m_de) return 53;
    if ((m_af & m_ae) != 0) return 52;
    if ((m_pf & m_pe) != 0) return 47;
    return 0;
  endfunction

  function automatic int exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return int'(m_pf);
      3'd1: return int'(m_pe);
      3'd2: return code_of(m_pf & m_pe, 8);
      3'd3: return int'(m_af);
      3'd4: return int'(m_ae);
      3'd5: return code_of({3'b0, m_af & m_ae}, 5);
      3'd6: return int'({m_de, m_df});
      default: return int'(m_gie);
    endcase
  endfunction

  task automatic step(input logic wr, input logic rd, input logic ack,
                      input logic [2:0] a, input logic [7:0] wd,
                      input logic [7:0] pev, input logic [4:0] aev, input logic dev);
    int cv, pc, ac;
    logic [7:0] npf, npe;
    logic [4:0] naf, nae;
    logic ndf, nde, ngie;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; irq_ack = ack; bus_addr = a; bus_wdata = wd;
    port_evt = pev; tmr_aux_evt = aev; tmr_ded_evt = dev;
    #1;
    cv = exp_vec();
    chk("R6 vector", int'(irq_vec), cv);
    chk("R7 request", int'(irq_req), int'(cv != 0));
    last_rd = bus_rdata;
    if (rd) chk((a == 3'd2) ? "R2 port code" : (a == 3'd5) ? "R5 aux code" : "R9 reg read",
                int'(bus_rdata), exp_rd(a));
    pc = code_of(m_pf & m_pe, 8);
    ac = code_of({3'b0, m_af & m_ae}, 5);
    npf = m_pf;
    if (wr && a == 3'd0) npf = wd;
    else if (rd && a == 3'd2 && pc != 0) npf[pc/2-1] = 1'b0;
    npf = npf | pev;
    npe = (wr && a == 3'd1) ? wd : m_pe;
    naf = m_af;
    if (wr && a == 3'd3) naf = wd[4:0];
    else if (rd && a == 3'd5 && ac != 0) naf[ac/2-1] = 1'b0;
    naf = naf | aev;
    nae = (wr && a == 3'd4) ? wd[4:0] : m_ae;
    ndf = m_df;
    if (wr && a == 3'd6) ndf = wd[0];
    else if (ack && cv == 53) ndf = 1'b0;
    ndf = ndf | dev;
    nde = (wr && a == 3'd6) ? wd[1] : m_de;
    ngie = (wr && a == 3'd7) ? wd[0] : m_gie;
    @(posedge clk);
    m_pf = npf; m_pe = npe; m_af = naf; m_ae = nae;
    m_df = ndf; m_de = nde; m_gie = ngie;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, 1'b0, 1'b0, a, d, 8'h0, 5'h0, 1'b0);
  endtask

  task automatic rd_reg(input logic [2:0] a);
    step(1'b0, 1'b1, 1'b0, a, 8'h0, 8'h0, 5'h0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 3'd0, 8'h0, 8'h0, 5'h0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_pf = '0; m_pe = '0; m_af = '0; m_ae = '0;
    m_df = 1'b0; m_de = 1'b0; m_gie = 1'b0;
    bus_wr = 0; bus_rd = 0; irq_ack = 0; bus_addr = 0; bus_wdata = 0;
    port_evt = 0; tmr_aux_evt = 0; tmr_ded_evt = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset vector", int'(irq_vec), 0);
    chk("R11 reset request", int'(irq_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R11 / R10: idle reads
    rd_reg(3'd2); chk("R10 idle port code", int'(last_rd), 0);
    rd_reg(3'd5); chk("R10 idle aux code", int'(last_rd), 0);
    rd_reg(3'd7); chk("R11 gie after reset", int'(last_rd), 0);

    // R1 R2 R3: pins 1 and 5
    wr_reg(3'd1, 8'h22);
    wr_reg(3'd7, 8'h01);
    step(1'b0, 1'b0, 1'b0, 3'd0, 8'h0, 8'h22, 5'h0, 1'b0);
    #1 chk("R1 port vector", int'(irq_vec), 47);
    rd_reg(3'd2); chk("R2 first code", int'(last_rd), 4);
    rd_reg(3'd0); chk("R3 pin5 kept", int'(last_rd), 8'h20);
    rd_reg(3'd2); chk("R3 second code", int'(last_rd), 12);
    #1 chk("R1 port idle", int'(irq_vec), 0);
    rd_reg(3'd2); chk("R10 empty code", int'(last_rd), 0);

    // R1: flag without enable
    step(1'b0, 1'b0, 1'b0, 3'd0, 8'h0, 8'h01, 5'h0, 1'b0);
    #1 chk("R1 disabled pin", int'(irq_vec), 0);
    wr_reg(3'd0, 8'h00);

    // R8: set beats read-clear on pin 3
    wr_reg(3'd1, 8'h08);
    wr_reg(3'd0, 8'h08);
    step(1'b0, 1'b1, 1'b0, 3'd2, 8'h0, 8'h08, 5'h0, 1'b0);
    chk("R8 code read", int'(last_rd), 8);
    rd_reg(3'd0); chk("R8 flag kept", int'(last_rd), 8'h08);
    wr_reg(3'd0, 8'h00);

    // R5 R6 R4: shared timer then dedicated
    wr_reg(3'd4, 8'h1f);
    step(1'b0, 1'b0, 1'b0, 3'd0, 8'h0, 8'h0, 5'h18, 1'b0);
    #1 chk("R5 aux vector", int'(irq_vec), 52);
    wr_reg(3'd6, 8'h03);
    #1 chk("R6 dedicated wins", int'(irq_vec), 53);
    step(1'b0, 1'b0, 1'b1, 3'd0, 8'h0, 8'h0, 5'h0, 1'b0);
    #1 chk("R4 ack clears", int'(irq_vec), 52);
    rd_reg(3'd6); chk("R4 flag low", int'(last_rd), 2);
    step(1'b0, 1'b0, 1'b1, 3'd0, 8'h0, 8'h0, 5'h0, 1'b0);
    rd_reg(3'd3); chk("R4 other ack no clear", int'(last_rd), 8'h18);
    rd_reg(3'd5); chk("R5 aux code", int'(last_rd), 8);
    step(1'b0, 1'b0, 1'b1, 3'd0, 8'h0, 8'h0, 5'h0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 3'd0, 8'h0, 8'h0, 5'h0, 1'b1);
    rd_reg(3'd6); chk("R8 ack vs set", int'(last_rd), 3);

    // R7: global enable off
    wr_reg(3'd7, 8'h00);
    #1 chk("R7 gated", int'(irq_vec), 0);
    rd_reg(3'd6); chk("R7 flag kept", int'(last_rd), 3);
    wr_reg(3'd7, 8'h01);
    #1 chk("R7 restored", int'(irq_vec), 53);

    // R9: software trigger
    wr_reg(3'd6, 8'h00);
    wr_reg(3'd0, 8'h80);
    wr_reg(3'd1, 8'h80);
    wr_reg(3'd3, 8'h00);
    #1 chk("R9 sw trigger", int'(irq_vec), 47);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int op;
      logic [2:0] a;
      logic [7:0] d, pev;
      logic [4:0] aev;
      logic dev;
      op  = int'($urandom % 8);
      d   = 8'($urandom);
      pev = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
      aev = ($urandom % 6 == 0) ? 5'($urandom) : 5'h00;
      dev = ($urandom % 9 == 0);
      case (op)
        0, 1: begin
          a = 3'($urandom);
          if (a == 3'd2 || a == 3'd5) a = 3'd1;
          if (a == 3'd7) d[0] = ($urandom % 4 != 0);
          step(1'b1, 1'b0, 1'b0, a, d, pev, aev, dev);
        end
        2, 3, 4: begin
          a = ($urandom % 2 == 0) ? 3'd2 : 3'd5;
          step(1'b0, 1'b1, 1'b0, a, 8'h0, pev, aev, dev);
        end
        5: step(1'b0, 1'b1, 1'b0, 3'($urandom), 8'h0, pev, aev, dev);
        6: step(1'b0, 1'b0, 1'b1, 3'd0, 8'h0, pev, aev, dev);
        default: step(1'b0, 1'b0, 1'b0, 3'd0, 8'h0, pev, aev, dev);
      endcase
    end
    idle();
    done = 1'b1;
    report();
  end
endmodule